// File: doc/BRIEF.md
# Write-Only Two-Wire Bias DAC Command Sender

This block sends one fixed-format command to a bias DAC over a two-wire serial line that is produced entirely by register writes. The clock line is bit 0 and the data line is bit 1 of an 8-bit power-control word. The remaining six bits of that word come from a base value supplied with the request and stay fixed for the whole transfer. Every line change is a separate write of (register address, word) on a valid/ready write port. Each accepted write is followed by a programmable hold time, counted in clock ticks.

A request carries the DAC value and the base word. The block then issues a complete frame and returns to idle. The frame is a start condition, the header byte 0x9C, an acknowledge slot, the byte 0x00, an acknowledge slot, the requested value, a final acknowledge slot and a stop condition. The acknowledge slots are only driven: the line is never sampled, and every slot is treated as acknowledged. The block reports busy for the whole transfer and gives a one-cycle done pulse when it finishes.

Top module: `twowire_dac_sender`

## Requirements
- R1: After reset, busy_o, done_o and wr_valid_o are all 0.
- R2: When idle, a start_i high at a clock edge is accepted. busy_o is 1 from the next cycle, and wr_valid_o presents the first write in that same cycle.
- R3: Every write uses address 0x03. Bits 7:2 of every written word equal bits 7:2 of base_i as sampled when the request was accepted.
- R4: The frame opens with three writes, given as (clock bit 0, data bit 1): (1,1), then (1,0), then (0,0).
- R5: Each data bit takes three writes with the data bit held at the bit value and the clock bit going 0, 1, 0. Bytes are sent most significant bit first.
- R6: After every byte comes one acknowledge slot: three writes with the data bit at 0 and the clock bit going 0, 1, 0.
- R7: The frame closes with three writes: (0,0), then (1,0), then (1,1).
- R8: A frame is exactly 87 writes. The bytes come in the order 0x9C, 0x00, then value_i as sampled at acceptance.
- R9: While wr_valid_o is 1 and wr_ready_i is 0, wr_valid_o, wr_addr_o and wr_data_o hold their values into the next cycle.
- R10: After each accepted write (wr_valid_o and wr_ready_i both 1 at an edge), wr_valid_o stays 0 for exactly HOLD_TICKS cycles before the next write is presented.
- R11: done_o is 1 for exactly one cycle. It rises HOLD_TICKS+1 cycles after the last write is accepted, and busy_o is 0 in that same cycle.
- R12: A start_i received while busy is ignored. The frame in progress keeps its contents, and no second frame follows.
- R13: Two consecutive writes of a frame differ in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send one frame |
| value_i | input | 8 | DAC value byte, sampled when the request is accepted |
| base_i | input | 8 | Base control word; bits 7:2 are sampled when the request is accepted |
| wr_valid_o | output | 1 | A write is presented |
| wr_ready_i | input | 1 | The register port takes the write this cycle |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | 8 | Word written: base bits with the clock at bit 0 and the data at bit 1 |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The first write is due in the cycle right after the accepting edge, so busy_o and wr_valid_o are checked one cycle after start_i is dropped. After each handshake, the monitor counts the cycles wr_valid_o spends low and expects exactly HOLD_TICKS of them, however long earlier writes were stalled by ready. The done pulse is expected HOLD_TICKS+1 cycles after the last accepted write, and done_o must be low again in the cycle after that. All sampling happens on the falling edge, and ready is changed just after the rising edge, so each handshake is observed in the cycle in which it takes effect.

// File: rtl/dac_tw_pkg.sv
package dac_tw_pkg;

    localparam int WORD_W      = 8;
    localparam int CLK_BIT     = 0;
    localparam int DAT_BIT     = 1;
    localparam int FRAME_BYTES = 3;
    localparam int BYTE_BITS   = 8;
    localparam int STEP_LAST   = 2;
    localparam logic [WORD_W-1:0] HDR_BYTE0 = 8'h9C;
    localparam logic [WORD_W-1:0] HDR_BYTE1 = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_ACK,
        PH_STOP
    } phase_e;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_ISSUE,
        WP_HOLD
    } port_e;

    typedef struct packed {
        logic clk_lvl;
        logic dat_lvl;
    } lines_t;

    function automatic lines_t phase_lines(phase_e ph, logic [1:0] step, logic bitval);
        lines_t l;
        l = '{clk_lvl: 1'b0, dat_lvl: 1'b0};
        unique case (ph)
            PH_START: begin
                l.clk_lvl = (step != 2'd2);
                l.dat_lvl = (step == 2'd0);
            end
            PH_DATA: begin
                l.clk_lvl = (step == 2'd1);
                l.dat_lvl = bitval;
            end
            PH_ACK: begin
                l.clk_lvl = (step == 2'd1);
                l.dat_lvl = 1'b0;
            end
            PH_STOP: begin
                l.clk_lvl = (step != 2'd0);
                l.dat_lvl = (step == 2'd2);
            end
            default: l = '{clk_lvl: 1'b0, dat_lvl: 1'b0};
        endcase
        return l;
    endfunction

    function automatic logic [WORD_W-1:0] frame_byte(logic [1:0] idx, logic [WORD_W-1:0] value);
        logic [WORD_W-1:0] b;
        unique case (idx)
            2'd0:    b = HDR_BYTE0;
            2'd1:    b = HDR_BYTE1;
            default: b = value;
        endcase
        return b;
    endfunction

    function automatic logic [WORD_W-1:0] merge_word(logic [WORD_W-3:0] base_hi, lines_t l);
        logic [WORD_W-1:0] w;
        w = {base_hi, 2'b00};
        w[CLK_BIT] = l.clk_lvl;
        w[DAT_BIT] = l.dat_lvl;
        return w;
    endfunction

endpackage

// File: rtl/dac_tw_stepper.sv
module dac_tw_stepper
    import dac_tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [WORD_W-1:0] value,
    output lines_t            lines,
    output logic              last
);
    localparam int BIT_W = $clog2(BYTE_BITS);

    phase_e           phase_q;
    logic [1:0]       step_q;
    logic [1:0]       byte_q;
    logic [BIT_W-1:0] bit_q;
    logic [WORD_W-1:0] cur_byte;

    assign cur_byte = frame_byte(byte_q, value);
    assign lines    = phase_lines(phase_q, step_q, cur_byte[bit_q]);
    assign last     = (phase_q == PH_STOP) && (step_q == 2'(STEP_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            byte_q  <= '0;
            bit_q   <= '0;
        end else if (load) begin
            phase_q <= PH_START;
            step_q  <= '0;
            byte_q  <= '0;
            bit_q   <= BIT_W'(BYTE_BITS - 1);
        end else if (adv) begin
            if (step_q != 2'(STEP_LAST)) begin
                step_q <= step_q + 2'd1;
            end else begin
                step_q <= '0;
                unique case (phase_q)
                    PH_START: begin
                        phase_q <= PH_DATA;
                        byte_q  <= '0;
                        bit_q   <= BIT_W'(BYTE_BITS - 1);
                    end
                    PH_DATA: begin
                        if (bit_q == '0) phase_q <= PH_ACK;
                        else             bit_q   <= bit_q - 1'b1;
                    end
                    PH_ACK: begin
                        if (byte_q == 2'(FRAME_BYTES - 1)) begin
                            phase_q <= PH_STOP;
                        end else begin
                            phase_q <= PH_DATA;
                            byte_q  <= byte_q + 2'd1;
                            bit_q   <= BIT_W'(BYTE_BITS - 1);
                        end
                    end
                    default: phase_q <= phase_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/dac_tw_hold_timer.sv
module dac_tw_hold_timer #(
    parameter int HOLD_TICKS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(HOLD_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || expired) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dac_tw_write_ctrl.sv
module dac_tw_write_ctrl
    import dac_tw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic wr_ready,
    input  logic hold_expired,
    input  logic last,
    output logic load,
    output logic adv,
    output logic issuing,
    output logic holding,
    output logic busy,
    output logic done
);
    port_e state_q, state_d;
    logic  done_q;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            WP_IDLE: if (start) begin
                state_d = WP_ISSUE;
                load    = 1'b1;
            end
            WP_ISSUE: if (wr_ready) state_d = WP_HOLD;
            WP_HOLD: if (hold_expired) begin
                if (last) begin
                    state_d = WP_IDLE;
                end else begin
                    state_d = WP_ISSUE;
                    adv     = 1'b1;
                end
            end
            default: state_d = WP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WP_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == WP_HOLD) && hold_expired && last;
        end
    end

    assign issuing = (state_q == WP_ISSUE);
    assign holding = (state_q == WP_HOLD);
    assign busy    = (state_q != WP_IDLE);
    assign done    = done_q;
endmodule

// File: rtl/twowire_dac_sender.sv
module twowire_dac_sender
    import dac_tw_pkg::*;
#(
    parameter int                HOLD_TICKS = 500,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [7:0]        value_i,
    input  logic [7:0]        base_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              busy_o,
    output logic              done_o
);
    logic [WORD_W-3:0] base_q;
    logic [WORD_W-1:0] value_q;
    logic              load, adv, issuing, holding, busy, last, hold_expired;
    lines_t            lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            value_q <= '0;
        end else if (load) begin
            base_q  <= base_i[WORD_W-1:2];
            value_q <= value_i;
        end
    end

    dac_tw_write_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start_i),
        .wr_ready     (wr_ready_i),
        .hold_expired (hold_expired),
        .last         (last),
        .load         (load),
        .adv          (adv),
        .issuing      (issuing),
        .holding      (holding),
        .busy         (busy),
        .done         (done_o)
    );

    dac_tw_stepper u_step (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv   (adv),
        .value (value_q),
        .lines (lines),
        .last  (last)
    );

    dac_tw_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .run     (holding),
        .expired (hold_expired)
    );

    assign wr_valid_o = issuing;
    assign wr_addr_o  = REG_ADDR;
    assign wr_data_o  = merge_word(base_q, lines);
    assign busy_o     = busy;
endmodule

// File: rtl/dac_tw_checker.sv
module dac_tw_checker #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h03
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [7:0]        wr_data_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [5:0]        base_q
);
    logic [7:0] prev_word;
    logic       have_prev;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) begin
            have_prev <= 1'b0;
            prev_word <= '0;
        end else if (wr_valid_o && wr_ready_i) begin
            have_prev <= 1'b1;
            prev_word <= wr_data_o;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !wr_valid_o);

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    assert_addr_base_R3: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> (wr_addr_o == REG_ADDR) && (wr_data_o[7:2] == base_q));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_data_o) && $stable(wr_addr_o));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_one_line_change_R13: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && wr_ready_i && have_prev) |-> ($countones(wr_data_o ^ prev_word) <= 1));
endmodule

bind twowire_dac_sender dac_tw_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .base_q     (base_q)
);

// File: tb/tb_twowire_dac_sender.sv
module tb_twowire_dac_sender;
    localparam int HOLD = 4;
    localparam int FRAME_WRITES = 87;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] value_i = '0;
    logic [7:0] base_i = '0;
    logic       wr_ready_i = 1'b1;
    logic       wr_valid_o, busy_o, done_o;
    logic [7:0] wr_addr_o, wr_data_o;

    twowire_dac_sender #(.HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i), .base_i(base_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit  stall_mode = 0;
    int  frame_writes = 0;
    int  frames_done = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(logic [7:0] b, bit c, bit d);
        return {b[7:2], d, c};
    endfunction

    task automatic push_frame(logic [7:0] b, logic [7:0] v);
        logic [7:0] bytes [3];
        bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = v;
        exp_q.push_back(mk(b,1,1)); tag_q.push_back("R4");
        exp_q.push_back(mk(b,1,0)); tag_q.push_back("R4");
        exp_q.push_back(mk(b,0,0)); tag_q.push_back("R4");
        for (int k = 0; k < 3; k++) begin
            for (int i = 7; i >= 0; i--) begin
                exp_q.push_back(mk(b,0,bytes[k][i])); tag_q.push_back("R5/R8");
                exp_q.push_back(mk(b,1,bytes[k][i])); tag_q.push_back("R5/R8");
                exp_q.push_back(mk(b,0,bytes[k][i])); tag_q.push_back("R5/R8");
            end
            exp_q.push_back(mk(b,0,0)); tag_q.push_back("R6");
            exp_q.push_back(mk(b,1,0)); tag_q.push_back("R6");
            exp_q.push_back(mk(b,0,0)); tag_q.push_back("R6");
        end
        exp_q.push_back(mk(b,0,0)); tag_q.push_back("R7");
        exp_q.push_back(mk(b,1,0)); tag_q.push_back("R7");
        exp_q.push_back(mk(b,1,1)); tag_q.push_back("R7");
    endtask

    task automatic pulse_start(logic [7:0] b, logic [7:0] v);
        @(posedge clk); #1;
        start_i = 1'b1; base_i = b; value_i = v;
        @(posedge clk); #1;
        start_i = 1'b0; base_i = ~b; value_i = ~v;
    endtask

    task automatic run_frame(logic [7:0] b, logic [7:0] v, bit stall, bit poke);
        int target;
        stall_mode = stall;
        frame_writes = 0;
        target = frames_done + 1;
        push_frame(b, v);
        pulse_start(b, v);
        @(negedge clk);
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        chk(wr_valid_o == 1'b1, "R2 first write presented", int'(wr_valid_o), 1);
        if (poke) begin
            repeat (60) @(posedge clk);
            pulse_start(8'h00, 8'hFF);   // R12: ignored while busy
            repeat (100) @(posedge clk);
            pulse_start(8'h33, 8'h11);
        end
        while (frames_done < target) @(posedge clk);
        @(negedge clk);
        chk(frame_writes == FRAME_WRITES, "R8 write count", frame_writes, FRAME_WRITES);
        chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
        repeat (30) @(negedge clk);
        chk(busy_o == 1'b0, "R12 no second frame busy", int'(busy_o), 0);
        chk(frame_writes == FRAME_WRITES, "R12 no extra writes", frame_writes, FRAME_WRITES);
    endtask

    // ready driver
    initial begin
        logic [7:0] lfsr = 8'hA7;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wr_ready_i = stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
        end
    end

    // monitor
    bit   gap_armed = 0;
    int   low_cnt = 0;
    bit   stall_pend = 0;
    logic [7:0] stall_word;
    bit   done_arm = 0;
    int   done_cnt = 0;
    bit   done_after = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_after) begin
                chk(done_o == 1'b0, "R11 done one cycle", int'(done_o), 0);
                done_after = 0;
            end else if (done_o && !done_arm) begin
                chk(0, "R11 unexpected done", 1, 0);
            end
            if (done_arm) begin
                done_cnt++;
                if (done_o) begin
                    chk(done_cnt == HOLD + 1, "R11 done timing", done_cnt, HOLD + 1);
                    chk(busy_o == 1'b0, "R11 busy low with done", int'(busy_o), 0);
                    done_arm = 0; done_after = 1; gap_armed = 0;
                    frames_done++;
                end else if (done_cnt > HOLD + 1) begin
                    chk(0, "R11 done missing", done_cnt, HOLD + 1);
                    done_arm = 0; frames_done++;
                end
            end
            if (stall_pend) begin
                chk(wr_valid_o && wr_data_o == stall_word, "R9 stalled write held",
                    int'(wr_data_o), int'(stall_word));
                stall_pend = 0;
            end
            if (gap_armed) begin
                if (!wr_valid_o) low_cnt++;
                else begin
                    chk(low_cnt == HOLD, "R10 hold gap", low_cnt, HOLD);
                    gap_armed = 0;
                end
            end
            if (wr_valid_o && !wr_ready_i) begin
                stall_pend = 1; stall_word = wr_data_o;
            end
            if (wr_valid_o && wr_ready_i) begin
                frame_writes++;
                chk(wr_addr_o == 8'h03, "R3 address", int'(wr_addr_o), 3);
                if (exp_q.size() == 0) begin
                    chk(0, "R12 unexpected write", int'(wr_data_o), 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(wr_data_o == e, {t, "/R3 word"}, int'(wr_data_o), int'(e));
                    if (exp_q.size() == 0) begin
                        done_arm = 1; done_cnt = 0;
                    end
                end
                gap_armed = 1; low_cnt = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1 done reset", int'(done_o), 0);
        chk(wr_valid_o == 1'b0, "R1 valid reset", int'(wr_valid_o), 0);
        run_frame(8'h00, 8'h7D, 0, 0);
        run_frame(8'hFC, 8'h00, 1, 0);
        run_frame(8'hA8, 8'hA5, 0, 1);
        run_frame(8'h57, 8'hFF, 1, 1);
        run_frame(8'h13, 8'h01, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule